// File: doc/BRIEF.md
# Channel Command Issue Decoder

This block sits in front of a set of I/O channels and turns an I/O start request into a channel set-up. A request carries a 16-bit device address, a 16-bit operation word and a start memory address. The channel number is taken from the device address. The request is refused when that channel is out of range or switched off, and also when the channel is busy. An accepted request produces one registered set-up pulse. The pulse loads the channel's memory address, clears its assembly register and sets its mode flags. It also issues a start strobe with an order toward the addressed device and marks the channel active. The channel stays active until the rest of the channel reports completion.

When the device address matches the disk pattern, the request is treated as a disk order. The low four address bits pick an order from a sparse sixteen-slot table. Empty slots, or stray address bits, turn the request into an immediate error. A disk request in load mode sends a special order in place of the table value. A disk request outside load mode runs the channel in 6-bit mode. The read, write and sense operations arm the matching pre-phase control flags. A seek order issued on a channel in overlap mode marks a seek in progress.

Top module: `chan_issue_dec`

## Requirements
- R1: The channel index is device address bits [14:12]. When the index is NCH or above, or its `chan_en` bit is 0, the response code is error (2'b10) and nothing is started.
- R2: On an enabled channel whose `chan_busy` input or `chan_active` output is 1, the response code is busy (2'b01) and nothing is started. Busy is decided before any disk order check, so a busy channel answers busy even for an invalid disk order.
- R3: Every request cycle is answered by `rsp_valid` for exactly one cycle, on the cycle after the request. The codes are ok 2'b00, busy 2'b01 and error 2'b10. An ok response comes with `ld_valid` and `start_stb` in the same cycle, carrying `ld_chan`, `ld_addr` = the request address and `start_dev` = the device address.
- R4: Operation bit 6 (octal 0100) sets `ld_norec`.
- R5: On a non-disk request, operation bit 7 (octal 0200) sets `ld_load`. When that bit is 0, `ld_wm` is set instead.
- R6: A request is a disk request when (dev & DISK_MASK) == (DISK_ADDR & DISK_MASK). The defaults are mask 16'h0FC0 and pattern 16'h0400. Device bits [3:0] index the order table {FF,82,84,86,00,89,88,83,87,04,80,FF,85,FF,FF,FF} (slot 0 first). The response is error when the slot holds FF or when device bit 4 or bit 5 is 1.
- R7: A disk request with operation bit 7 set gives `start_order` 9'h100, with `ld_load`, `ld_wm` and `ld_six` all 0. Without bit 7 it gives `start_order` = table value and sets both `ld_six` and `ld_wm`.
- R8: Every accepted disk request sets `ld_cntl`, `ld_data_pend` and `ld_eor_clr`. Its operation code (operation bits [14:8]) equal to OP_RD, OP_WR or OP_SNS (defaults 1, 2, 3) sets `ld_pread`, `ld_pwrite` or `ld_sense` respectively.
- R9: `ld_seek` is set only by a disk request whose table value is 8'h80 (slot 10), issued outside load mode, on a channel whose `chan_ovlp` bit is 1.
- R10: The addressed `chan_active` bit becomes 1 in the cycle of `start_stb`. It returns to 0 on the clock edge at which its `chan_done` bit is sampled high.
- R11: A non-disk request gives `start_order` = {2'b00, operation code} and leaves `ld_six`, `ld_cntl`, `ld_pread`, `ld_pwrite`, `ld_sense`, `ld_data_pend`, `ld_eor_clr` and `ld_seek` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request present this cycle |
| req_dev | input | 16 | Device address |
| req_op | input | 16 | Operation word (opcode in [14:8], load [7], no-record-stop [6]) |
| req_addr | input | AW | Start memory address |
| chan_en | input | NCH | Channel enabled |
| chan_busy | input | NCH | Channel selected, disconnecting or waiting |
| chan_done | input | NCH | Channel finished; clears its active bit |
| chan_ovlp | input | NCH | Channel runs overlapped |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | Response code |
| ld_valid | output | 1 | Channel set-up pulse (also clears assembly) |
| ld_chan | output | 3 | Channel being set up |
| ld_addr | output | AW | Value for the channel address register |
| ld_norec | output | 1 | No-record-stop mode |
| ld_load | output | 1 | Load mode |
| ld_wm | output | 1 | Pending word mark on first character |
| ld_six | output | 1 | 6-bit mode |
| ld_cntl | output | 1 | Control phase pending |
| ld_pread | output | 1 | Pre-read pending |
| ld_pwrite | output | 1 | Pre-write pending |
| ld_sense | output | 1 | Sense pending |
| ld_data_pend | output | 1 | Disk data phase pending |
| ld_eor_clr | output | 1 | Clear stale device end-of-record |
| ld_seek | output | 1 | Seek in progress, seek-done cleared |
| start_stb | output | 1 | Start strobe toward the device |
| start_dev | output | 16 | Device address of the start |
| start_order | output | 9 | Order sent with the start |
| chan_active | output | NCH | Channel active flags |

## Verification
The bench walks every one of the sixteen disk order slots. An error in the sparse table would show up as a wrong order or as a missing error response. It sets the stray address bits on a valid slot, which a decoder that checks only the table would accept. It sends a seek in load mode, where a design that tested the order before replacing it with the load order would wrongly flag a seek. It also sends an invalid disk order to a busy channel. A design that checked the table before the busy state would answer error there instead of busy. Other cases check that a disabled or out-of-range channel returns error, and that re-issuing to a channel left active returns busy until its done pulse arrives.

// File: rtl/chan_dec_pkg.sv
package chan_dec_pkg;
  localparam int CHW = 3;

  typedef enum logic [1:0] {
    RSP_OK   = 2'b00,
    RSP_BUSY = 2'b01,
    RSP_ERR  = 2'b10
  } rsp_e;

  // Sparse disk order table; 8'hFF marks an empty slot.
  function automatic logic [7:0] disk_order(input logic [3:0] idx);
    case (idx)
      4'd1:    return 8'h82;
      4'd2:    return 8'h84;
      4'd3:    return 8'h86;
      4'd4:    return 8'h00;
      4'd5:    return 8'h89;
      4'd6:    return 8'h88;
      4'd7:    return 8'h83;
      4'd8:    return 8'h87;
      4'd9:    return 8'h04;
      4'd10:   return 8'h80;
      4'd12:   return 8'h85;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic order_valid(input logic [7:0] ord);
    return ord != 8'hFF;
  endfunction
endpackage

// File: rtl/chan_sel_check.sv
module chan_sel_check #(
  parameter int NCH = 4
) (
  input  logic [chan_dec_pkg::CHW-1:0] idx,
  input  logic [NCH-1:0]               en,
  input  logic [NCH-1:0]               busy,
  input  logic [NCH-1:0]               active,
  output logic [NCH-1:0]               hit,
  output logic                         disabled,
  output logic                         occupied
);
  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = (idx == chan_dec_pkg::CHW'(i));
  end

  assign disabled = ~|(hit & en);
  assign occupied = |(hit & (busy | active));
endmodule

// File: rtl/disk_order_map.sv
module disk_order_map #(
  parameter logic [15:0] DISK_ADDR = 16'h0400,
  parameter logic [15:0] DISK_MASK = 16'h0FC0
) (
  input  logic [15:0] dev,
  output logic        is_disk,
  output logic        order_ok,
  output logic [7:0]  order
);
  logic stray;

  assign is_disk  = (dev & DISK_MASK) == (DISK_ADDR & DISK_MASK);
  assign stray    = |dev[5:4];
  assign order    = chan_dec_pkg::disk_order(dev[3:0]);
  assign order_ok = chan_dec_pkg::order_valid(order) && !stray;
endmodule

// File: rtl/chan_active_reg.sv
module chan_active_reg #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] active
);
  for (genvar i = 0; i < NCH; i++) begin : g_act
    always_ff @(posedge clk) begin
      if (!rst_n)          active[i] <= 1'b0;
      else if (set_vec[i]) active[i] <= 1'b1;
      else if (clr_vec[i]) active[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_issue_dec.sv
module chan_issue_dec #(
  parameter int          NCH       = 4,
  parameter int          AW        = 16,
  parameter logic [15:0] DISK_ADDR = 16'h0400,
  parameter logic [15:0] DISK_MASK = 16'h0FC0,
  parameter logic [6:0]  OP_RD     = 7'd1,
  parameter logic [6:0]  OP_WR     = 7'd2,
  parameter logic [6:0]  OP_SNS    = 7'd3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [15:0]    req_dev,
  input  logic [15:0]    req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] chan_busy,
  input  logic [NCH-1:0] chan_done,
  input  logic [NCH-1:0] chan_ovlp,
  output logic           rsp_valid,
  output logic [1:0]     rsp_code,
  output logic           ld_valid,
  output logic [2:0]     ld_chan,
  output logic [AW-1:0]  ld_addr,
  output logic           ld_norec,
  output logic           ld_load,
  output logic           ld_wm,
  output logic           ld_six,
  output logic           ld_cntl,
  output logic           ld_pread,
  output logic           ld_pwrite,
  output logic           ld_sense,
  output logic           ld_data_pend,
  output logic           ld_eor_clr,
  output logic           ld_seek,
  output logic           start_stb,
  output logic [15:0]    start_dev,
  output logic [8:0]     start_order,
  output logic [NCH-1:0] chan_active
);
  import chan_dec_pkg::*;

  localparam logic [7:0] SEEK_ORDER = 8'h80;
  localparam logic [8:0] LOAD_ORDER = 9'h100;

  logic [CHW-1:0] ch_idx;
  logic [NCH-1:0] ch_hit;
  logic           ch_disabled, ch_occupied;
  logic           is_disk, disk_ok;
  logic [7:0]     disk_ord;
  logic [6:0]     opc;
  logic           op_load, op_norec;
  logic           unused_op;

  // Named events for the checker
  logic ev_err, ev_busy, ev_accept;

  assign ch_idx    = req_dev[14:12];
  assign opc       = req_op[14:8];
  assign op_load   = req_op[7];
  assign op_norec  = req_op[6];
  assign unused_op = ^{req_op[15], req_op[5:0], req_dev[15]};

  chan_sel_check #(.NCH(NCH)) u_sel (
    .idx(ch_idx), .en(chan_en), .busy(chan_busy), .active(chan_active),
    .hit(ch_hit), .disabled(ch_disabled), .occupied(ch_occupied)
  );

  disk_order_map #(.DISK_ADDR(DISK_ADDR), .DISK_MASK(DISK_MASK)) u_map (
    .dev(req_dev), .is_disk(is_disk), .order_ok(disk_ok), .order(disk_ord)
  );

  // Priority: disabled, then busy, then disk order validity
  assign ev_err    = req_valid && (ch_disabled || (!ch_occupied && is_disk && !disk_ok));
  assign ev_busy   = req_valid && !ch_disabled && ch_occupied;
  assign ev_accept = req_valid && !ev_err && !ev_busy;

  chan_active_reg #(.NCH(NCH)) u_act (
    .clk(clk), .rst_n(rst_n),
    .set_vec(ch_hit & {NCH{ev_accept}}),
    .clr_vec(chan_done),
    .active(chan_active)
  );

  // Next set-up values
  logic       n_load, n_wm, n_six, n_seek;
  logic [8:0] n_order;

  always_comb begin
    if (is_disk) begin
      n_load  = 1'b0;
      n_wm    = !op_load;
      n_six   = !op_load;
      n_order = op_load ? LOAD_ORDER : {1'b0, disk_ord};
      n_seek  = !op_load && (disk_ord == SEEK_ORDER) && |(ch_hit & chan_ovlp);
    end else begin
      n_load  = op_load;
      n_wm    = !op_load;
      n_six   = 1'b0;
      n_order = {2'b00, opc};
      n_seek  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= RSP_OK;
      ld_valid     <= 1'b0;
      start_stb    <= 1'b0;
      ld_chan      <= '0;
      ld_addr      <= '0;
      ld_norec     <= 1'b0;
      ld_load      <= 1'b0;
      ld_wm        <= 1'b0;
      ld_six       <= 1'b0;
      ld_cntl      <= 1'b0;
      ld_pread     <= 1'b0;
      ld_pwrite    <= 1'b0;
      ld_sense     <= 1'b0;
      ld_data_pend <= 1'b0;
      ld_eor_clr   <= 1'b0;
      ld_seek      <= 1'b0;
      start_dev    <= '0;
      start_order  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= ev_err ? RSP_ERR : (ev_busy ? RSP_BUSY : RSP_OK);
      ld_valid  <= ev_accept;
      start_stb <= ev_accept;
      if (ev_accept) begin
        ld_chan      <= ch_idx;
        ld_addr      <= req_addr;
        ld_norec     <= op_norec;
        ld_load      <= n_load;
        ld_wm        <= n_wm;
        ld_six       <= n_six;
        ld_cntl      <= is_disk;
        ld_pread     <= is_disk && (opc == OP_RD);
        ld_pwrite    <= is_disk && (opc == OP_WR);
        ld_sense     <= is_disk && (opc == OP_SNS);
        ld_data_pend <= is_disk;
        ld_eor_clr   <= is_disk;
        ld_seek      <= n_seek;
        start_dev    <= req_dev;
        start_order  <= n_order;
      end
    end
  end
endmodule

// File: rtl/chan_issue_dec_chk.sv
module chan_issue_dec_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [15:0]    req_dev,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] chan_done,
  input logic           rsp_valid,
  input logic [1:0]     rsp_code,
  input logic           ld_valid,
  input logic           ld_load,
  input logic           ld_six,
  input logic           ld_seek,
  input logic           start_stb,
  input logic [8:0]     start_order,
  input logic [NCH-1:0] chan_active
);
  logic act_hit;
  assign act_hit = |((chan_active & chan_en) & (NCH'(1) << req_dev[14:12]));

  p_rsp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'b11));
  p_start_with_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> (rsp_valid && rsp_code == 2'b00 && ld_valid));
  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'b00) |-> (!start_stb && !ld_valid));
  p_active_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && act_hit) |=> (rsp_code == 2'b01));
  p_load_not_six_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !(ld_load && ld_six));
  p_seek_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_seek) |-> (start_order == 9'h080));
  p_active_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_active & ~$past(chan_active))) |-> start_stb);
  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_done & chan_active)) |=> ((chan_active & $past(chan_done & chan_active)) == '0));
endmodule

bind chan_issue_dec chan_issue_dec_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
  .chan_en(chan_en), .chan_done(chan_done), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .ld_valid(ld_valid), .ld_load(ld_load),
  .ld_six(ld_six), .ld_seek(ld_seek), .start_stb(start_stb),
  .start_order(start_order), .chan_active(chan_active)
);

// File: tb/chan_issue_dec_tb_top.sv
`timescale 1ns/1ps
module chan_issue_dec_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [15:0]    req_dev = '0, req_op = '0;
  logic [AW-1:0]  req_addr = '0;
  logic [NCH-1:0] chan_en = '1, chan_busy = '0, chan_done = '0, chan_ovlp = '0;
  logic           rsp_valid, ld_valid, start_stb;
  logic [1:0]     rsp_code;
  logic [2:0]     ld_chan;
  logic [AW-1:0]  ld_addr;
  logic ld_norec, ld_load, ld_wm, ld_six, ld_cntl, ld_pread, ld_pwrite;
  logic ld_sense, ld_data_pend, ld_eor_clr, ld_seek;
  logic [15:0]    start_dev;
  logic [8:0]     start_order;
  logic [NCH-1:0] chan_active;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [8:0] exp_tab [16];

  always #2.5 clk = ~clk;

  chan_issue_dec #(.NCH(NCH), .AW(AW)) dut_i (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkdev(input int ch, input bit disk,
                                        input logic [1:0] stray, input logic [3:0] idx);
    return {1'b0, 3'(ch), (disk ? 6'b010000 : 6'b000001), stray, idx};
  endfunction

  function automatic logic [15:0] mkop(input logic [6:0] opc, input bit ld, input bit nr);
    return {1'b0, opc, ld, nr, 6'b0};
  endfunction

  // Drive one request; outputs sampled 1 ns after the capturing edge.
  task automatic issue(input logic [15:0] dev, input logic [15:0] op, input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_op = op; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic release_ch(input int ch);
    @(negedge clk);
    chan_done = NCH'(1) << ch;
    @(posedge clk); #1;
    chan_done = '0;
    chk("R10", "active cleared by done", 32'(chan_active[ch]), 0);
  endtask

  task automatic t_reset;
    chk("R3", "reset rsp_valid", 32'(rsp_valid), 0);
    chk("R3", "reset start_stb", 32'(start_stb), 0);
    chk("R10", "reset active", 32'(chan_active), 0);
  endtask

  task automatic t_disabled;
    chan_en = 4'b1011;
    issue(mkdev(2, 0, 0, 0), mkop(7'd1, 0, 0), 16'h10);
    chk("R1", "disabled code", 32'(rsp_code), 2);
    chk("R1", "disabled no start", 32'(start_stb), 0);
    chan_en = '1;
    issue(mkdev(5, 0, 0, 0), mkop(7'd1, 0, 0), 16'h10);
    chk("R1", "out of range code", 32'(rsp_code), 2);
    chk("R10", "no active on error", 32'(chan_active), 0);
  endtask

  task automatic t_nondisk;
    issue(mkdev(0, 0, 0, 3), mkop(7'd1, 0, 1), 16'h1234);
    chk("R3", "ok code", 32'(rsp_code), 0);
    chk("R3", "ld_valid", 32'(ld_valid), 1);
    chk("R3", "start_stb", 32'(start_stb), 1);
    chk("R3", "ld_addr", 32'(ld_addr), 32'h1234);
    chk("R3", "ld_chan", 32'(ld_chan), 0);
    chk("R3", "start_dev", 32'(start_dev), 32'(mkdev(0, 0, 0, 3)));
    chk("R4", "norec", 32'(ld_norec), 1);
    chk("R5", "wm when not load", 32'(ld_wm), 1);
    chk("R5", "load clear", 32'(ld_load), 0);
    chk("R11", "order=opcode", 32'(start_order), 1);
    chk("R11", "no disk flags", 32'({ld_six, ld_cntl, ld_data_pend, ld_eor_clr, ld_seek}), 0);
    chk("R10", "active set", 32'(chan_active), 1);
    @(posedge clk); #1;
    chk("R3", "single-cycle response", 32'(rsp_valid), 0);
    issue(mkdev(0, 0, 0, 3), mkop(7'd1, 0, 0), 16'h5);
    chk("R2", "active channel busy", 32'(rsp_code), 1);
    chk("R2", "busy no start", 32'(start_stb), 0);
    release_ch(0);
    issue(mkdev(3, 0, 0, 0), mkop(7'd4, 1, 0), 16'h77);
    chk("R5", "load set", 32'(ld_load), 1);
    chk("R5", "wm clear in load", 32'(ld_wm), 0);
    chk("R4", "norec clear", 32'(ld_norec), 0);
    chk("R11", "order=opcode 4", 32'(start_order), 4);
    chk("R3", "ld_chan 3", 32'(ld_chan), 3);
    release_ch(3);
  endtask

  task automatic t_busy_input;
    chan_busy = 4'b0010;
    issue(mkdev(1, 0, 0, 0), mkop(7'd1, 0, 0), 16'h0);
    chk("R2", "busy input", 32'(rsp_code), 1);
    issue(mkdev(1, 1, 0, 11), mkop(7'd1, 0, 0), 16'h0);
    chk("R2", "busy over invalid disk", 32'(rsp_code), 1);
    chan_busy = '0;
  endtask

  task automatic t_disk_table;
    for (int i = 0; i < 16; i++) begin
      issue(mkdev(1, 1, 0, 4'(i)), mkop(7'd5, 0, 0), 16'(i));
      if (exp_tab[i] == 9'h0FF) begin
        chk("R6", "invalid slot error", 32'(rsp_code), 2);
      end else begin
        chk("R6", "valid slot ok", 32'(rsp_code), 0);
        chk("R7", "table order", 32'(start_order), 32'(exp_tab[i]));
        chk("R7", "six and wm", 32'({ld_six, ld_wm, ld_load}), 3'b110);
        chk("R8", "cntl/data/eor", 32'({ld_cntl, ld_data_pend, ld_eor_clr}), 3'b111);
        release_ch(1);
      end
    end
    issue(mkdev(1, 1, 2'b01, 1), mkop(7'd1, 0, 0), 16'h0);
    chk("R6", "stray bit 4 error", 32'(rsp_code), 2);
    issue(mkdev(1, 1, 2'b10, 2), mkop(7'd1, 0, 0), 16'h0);
    chk("R6", "stray bit 5 error", 32'(rsp_code), 2);
  endtask

  task automatic t_disk_load_ops;
    issue(mkdev(2, 1, 0, 5), mkop(7'd1, 1, 0), 16'h40);
    chk("R7", "load order 100", 32'(start_order), 32'h100);
    chk("R7", "load flags clear", 32'({ld_load, ld_wm, ld_six}), 0);
    chk("R8", "pread", 32'({ld_pread, ld_pwrite, ld_sense}), 3'b100);
    release_ch(2);
    issue(mkdev(2, 1, 0, 6), mkop(7'd2, 0, 0), 16'h41);
    chk("R8", "pwrite", 32'({ld_pread, ld_pwrite, ld_sense}), 3'b010);
    release_ch(2);
    issue(mkdev(2, 1, 0, 7), mkop(7'd3, 0, 0), 16'h42);
    chk("R8", "sense", 32'({ld_pread, ld_pwrite, ld_sense}), 3'b001);
    chk("R8", "cntl", 32'(ld_cntl), 1);
    release_ch(2);
  endtask

  task automatic t_seek;
    chan_ovlp = 4'b0100;
    issue(mkdev(2, 1, 0, 10), mkop(7'd4, 0, 0), 16'h0);
    chk("R9", "seek with overlap", 32'(ld_seek), 1);
    chk("R9", "seek order", 32'(start_order), 32'h080);
    release_ch(2);
    issue(mkdev(2, 1, 0, 10), mkop(7'd4, 1, 0), 16'h0);
    chk("R9", "no seek in load", 32'(ld_seek), 0);
    release_ch(2);
    issue(mkdev(1, 1, 0, 10), mkop(7'd4, 0, 0), 16'h0);
    chk("R9", "no seek without overlap", 32'(ld_seek), 0);
    release_ch(1);
    issue(mkdev(2, 1, 0, 3), mkop(7'd4, 0, 0), 16'h0);
    chk("R9", "no seek other order", 32'(ld_seek), 0);
    release_ch(2);
    chan_ovlp = '0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_tab[i] = 9'h0FF;
    exp_tab[1] = 9'h82;  exp_tab[2] = 9'h84;  exp_tab[3] = 9'h86;
    exp_tab[4] = 9'h00;  exp_tab[5] = 9'h89;  exp_tab[6] = 9'h88;
    exp_tab[7] = 9'h83;  exp_tab[8] = 9'h87;  exp_tab[9] = 9'h04;
    exp_tab[10] = 9'h80; exp_tab[12] = 9'h85;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_disabled();
    t_nondisk();
    t_busy_input();
    t_disk_table();
    t_disk_load_ops();
    t_seek();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule